// File: doc/BRIEF.md
# Indexed Super-I/O Configuration Window

This block exposes a 256-byte configuration array through a pair of byte-wide I/O ports. Software first writes an index byte to the lower port, then reads or writes the selected array entry through the upper port. The array holds the settings used by on-board peripheral controllers. Those controllers live outside this block and read the array contents elsewhere.

Data-port writes pass through a fixed write-protection policy. Large index ranges are read-only. Two entries act as keyed locations that accept only one exact byte, and all remaining entries accept any value. Reads are never filtered: every entry, protected or not, can be read back. The whole window responds only while an enable input is high. That input is driven by one bit of a bridge configuration register outside this block. While the window is disabled, it returns all-ones on reads and ignores writes.

Accesses are single bytes. Read data is registered and appears one clock after the read strobe. The output then holds that value until the next read.

Top module: `sio_cfg_window`

## Requirements
- R1: A write strobe at address BASE_ADDR (default 0x3F0) with the window enabled loads the write byte into the index register.
- R2: A read strobe at BASE_ADDR+1 with the window enabled returns, one clock later on the read-data output, the array entry selected by the index. The read-data output keeps its value in every cycle that has no read strobe.
- R3: After synchronous reset, entries 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE. Every other entry and the index are 0x00, and the read-data output is 0xFF.
- R4: Data-port writes are dropped when the index is any of the following: 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R5: A data-port write to index 0xE7 is stored only when the byte is 0xFE. Otherwise the entry keeps its value.
- R6: A data-port write to index 0xE8 is stored only when the byte is 0xBE. Otherwise the entry keeps its value.
- R7: Data-port writes to every remaining index (0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8, 0xFC) store the byte unchanged.
- R8: While the enable input is low, a read strobe returns 0xFF one clock later. Writes to either port change neither the index nor any entry.
- R9: Strobes at addresses other than BASE_ADDR and BASE_ADDR+1 have no effect: writes alter neither the index nor any entry, and reads leave the read-data output unchanged.
- R10: A read strobe at BASE_ADDR with the window enabled also returns the entry selected by the index, exactly as a data-port read does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| win_en | input | 1 | Window enable from the bridge configuration bit |
| io_addr | input | ADDR_W (16) | I/O address of the current access |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wr | input | 1 | Single-cycle write strobe |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Registered read byte |

## Verification
The bench builds the block with its default parameters: a 16-bit address bus and the window based at 0x3F0. With this setup, the exact decode of both ports can be tested directly. The neighbouring addresses 0x3EF and 0x3F2 are also reachable, which exposes any aliasing of the window. With the default 8-bit index, the bench can sweep all 256 entries. This covers every boundary of the protection ranges and both keyed entries, checked against accepted and rejected bytes.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int CFG_DW = 8;
  localparam int CFG_IW = 8;
  localparam int CFG_NUM = 1 << CFG_IW;

  typedef logic [CFG_DW-1:0] cfg_byte_t;

  typedef enum logic [1:0] {
    WR_OPEN   = 2'd0,
    WR_LOCKED = 2'd1,
    WR_KEYED  = 2'd2
  } wr_policy_e;

  // Write policy attached to each index of the array.
  function automatic wr_policy_e policy_of(cfg_byte_t idx);
    wr_policy_e p;
    if (idx < 8'hE0) begin
      p = WR_LOCKED;
    end else begin
      case (idx) inside
        8'hE4, 8'hE5, [8'hE9:8'hED], 8'hF3, 8'hF5, 8'hF7,
        [8'hF9:8'hFB], [8'hFD:8'hFF]: p = WR_LOCKED;
        8'hE7, 8'hE8:                 p = WR_KEYED;
        default:                      p = WR_OPEN;
      endcase
    end
    return p;
  endfunction

  // The single byte a keyed entry will accept.
  function automatic cfg_byte_t key_of(cfg_byte_t idx);
    cfg_byte_t k;
    case (idx)
      8'hE7:   k = 8'hFE;
      8'hE8:   k = 8'hBE;
      default: k = 8'h00;
    endcase
    return k;
  endfunction

  function automatic logic wr_permitted(cfg_byte_t idx, cfg_byte_t data);
    logic ok;
    case (policy_of(idx))
      WR_OPEN:  ok = 1'b1;
      WR_KEYED: ok = (data == key_of(idx));
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Power-on content of each entry.
  function automatic cfg_byte_t reset_value(cfg_byte_t idx);
    cfg_byte_t v;
    case (idx)
      8'hE0:   v = 8'h3C;
      8'hE2:   v = 8'h03;
      8'hE3:   v = 8'hFC;
      8'hE6:   v = 8'hDE;
      8'hE7:   v = 8'hFE;
      8'hE8:   v = 8'hBE;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic              win_en,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic              idx_wr,
  output logic              dat_wr,
  output logic              win_rd,
  output logic              off_rd
);

  localparam logic [ADDR_W-1:0] IDX_PORT = BASE_ADDR;
  localparam logic [ADDR_W-1:0] DAT_PORT = BASE_ADDR + ADDR_W'(1);

  logic at_idx;
  logic at_dat;
  logic in_win;

  always_comb begin
    at_idx = (io_addr == IDX_PORT);
    at_dat = (io_addr == DAT_PORT);
    in_win = at_idx || at_dat;
    idx_wr = win_en && io_wr && at_idx;
    dat_wr = win_en && io_wr && at_dat;
    // Reads at either port return the selected entry.
    win_rd = win_en && io_rd && in_win;
    // Disabled reads anywhere in the window report the idle pattern.
    off_rd = !win_en && io_rd && in_win;
  end

endmodule

// File: rtl/sio_idx_reg.sv
module sio_idx_reg
  import sio_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  cfg_byte_t din,
  output cfg_byte_t idx
);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (load) begin
      idx <= din;
    end
  end

endmodule

// File: rtl/sio_wr_guard.sv
module sio_wr_guard
  import sio_cfg_pkg::*;
(
  input  logic       dat_wr,
  input  cfg_byte_t  idx,
  input  cfg_byte_t  wdata,
  output logic       commit,
  output wr_policy_e policy
);

  always_comb begin
    policy = policy_of(idx);
    commit = dat_wr && wr_permitted(idx, wdata);
  end

endmodule

// File: rtl/sio_cfg_store.sv
module sio_cfg_store
  import sio_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  cfg_byte_t waddr,
  input  cfg_byte_t wdata,
  input  cfg_byte_t raddr,
  output cfg_byte_t rdata
);

  cfg_byte_t mem [CFG_NUM];

  for (genvar g = 0; g < CFG_NUM; g++) begin : g_entry
    localparam cfg_byte_t MY_IDX = cfg_byte_t'(g);
    localparam cfg_byte_t MY_RST = reset_value(MY_IDX);
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[g] <= MY_RST;
      end else if (we && (waddr == MY_IDX)) begin
        mem[g] <= wdata;
      end
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sio_rd_port.sv
module sio_rd_port
  import sio_cfg_pkg::*;
#(
  parameter cfg_byte_t IDLE_BYTE = 8'hFF
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      win_rd,
  input  logic      off_rd,
  input  cfg_byte_t entry,
  output cfg_byte_t rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= IDLE_BYTE;
    end else if (win_rd) begin
      rdata <= entry;
    end else if (off_rd) begin
      rdata <= IDLE_BYTE;
    end
  end

endmodule

// File: rtl/sio_cfg_window.sv
module sio_cfg_window
  import sio_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_en,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata
);

  logic       idx_wr;
  logic       dat_wr;
  logic       win_rd;
  logic       off_rd;
  cfg_byte_t  idx_q;
  cfg_byte_t  entry_q;
  logic       wr_commit;
  wr_policy_e wr_policy;

  sio_addr_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dec (
    .win_en  (win_en),
    .io_addr (io_addr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .idx_wr  (idx_wr),
    .dat_wr  (dat_wr),
    .win_rd  (win_rd),
    .off_rd  (off_rd)
  );

  sio_idx_reg u_idx (
    .clk  (clk),
    .rst  (rst),
    .load (idx_wr),
    .din  (io_wdata),
    .idx  (idx_q)
  );

  sio_wr_guard u_guard (
    .dat_wr (dat_wr),
    .idx    (idx_q),
    .wdata  (io_wdata),
    .commit (wr_commit),
    .policy (wr_policy)
  );

  sio_cfg_store u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_commit),
    .waddr (idx_q),
    .wdata (io_wdata),
    .raddr (idx_q),
    .rdata (entry_q)
  );

  sio_rd_port #(
    .IDLE_BYTE (8'hFF)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .win_rd (win_rd),
    .off_rd (off_rd),
    .entry  (entry_q),
    .rdata  (io_rdata)
  );

endmodule

// File: rtl/sio_cfg_window_chk.sv
module sio_cfg_window_chk
  import sio_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input logic              clk,
  input logic              rst,
  input logic              win_en,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input cfg_byte_t         idx_q,
  input logic              wr_commit
);

  logic idx_strobe;
  logic dat_strobe;
  assign idx_strobe = win_en && io_wr && (io_addr == BASE_ADDR);
  assign dat_strobe = io_wr && (io_addr == BASE_ADDR + ADDR_W'(1));

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (rst)
    idx_strobe |=> (idx_q == $past(io_wdata))); // R1

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !idx_strobe |=> $stable(idx_q)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata)); // R2

  AST_LOW_RANGE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (dat_strobe && (idx_q < 8'hE0)) |-> !wr_commit); // R4

  AST_KEY_E7: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && (idx_q == 8'hE7)) |-> (io_wdata == 8'hFE)); // R5

  AST_KEY_E8: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && (idx_q == 8'hE8)) |-> (io_wdata == 8'hBE)); // R6

  AST_COMMIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> (dat_strobe && win_en)); // R8

  AST_DISABLED_READ: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !win_en && ((io_addr == BASE_ADDR) || (io_addr == BASE_ADDR + ADDR_W'(1))))
      |=> (io_rdata == 8'hFF)); // R8

endmodule

bind sio_cfg_window sio_cfg_window_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .win_en    (win_en),
  .io_addr   (io_addr),
  .io_rd     (io_rd),
  .io_wr     (io_wr),
  .io_wdata  (io_wdata),
  .io_rdata  (io_rdata),
  .idx_q     (idx_q),
  .wr_commit (wr_commit)
);

// File: tb/test_sio_cfg_window.sv
module test_sio_cfg_window;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        win_en = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  localparam logic [15:0] P_IDX = 16'h03F0;
  localparam logic [15:0] P_DAT = 16'h03F1;

  always #10 clk = ~clk;

  sio_cfg_window i_sio_cfg_window (
    .clk      (clk),
    .rst      (rst),
    .win_en   (win_en),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata)
  );

  // {tag, index, write byte, expected read-back}
  localparam int NV = 28;
  localparam logic [27:0] VEC [NV] = '{
    {4'd4, 8'h00, 8'h55, 8'h00}, {4'd4, 8'hDF, 8'hAA, 8'h00},
    {4'd7, 8'hE0, 8'h12, 8'h12}, {4'd4, 8'hE4, 8'h77, 8'h00},
    {4'd4, 8'hE5, 8'h77, 8'h00}, {4'd5, 8'hE7, 8'h00, 8'hFE},
    {4'd5, 8'hE7, 8'hFF, 8'hFE}, {4'd5, 8'hE7, 8'hFE, 8'hFE},
    {4'd6, 8'hE8, 8'h12, 8'hBE}, {4'd6, 8'hE8, 8'hBF, 8'hBE},
    {4'd6, 8'hE8, 8'hBE, 8'hBE}, {4'd4, 8'hE9, 8'h33, 8'h00},
    {4'd4, 8'hED, 8'h33, 8'h00}, {4'd7, 8'hEE, 8'hA5, 8'hA5},
    {4'd4, 8'hF3, 8'h11, 8'h00}, {4'd4, 8'hF5, 8'h11, 8'h00},
    {4'd4, 8'hF7, 8'h11, 8'h00}, {4'd4, 8'hFA, 8'h11, 8'h00},
    {4'd4, 8'hFD, 8'h11, 8'h00}, {4'd4, 8'hFF, 8'h11, 8'h00},
    {4'd7, 8'hF4, 8'h5A, 8'h5A}, {4'd7, 8'hF6, 8'hC3, 8'hC3},
    {4'd7, 8'hF8, 8'h3C, 8'h3C}, {4'd7, 8'hFC, 8'h81, 8'h81},
    {4'd7, 8'hE6, 8'h01, 8'h01}, {4'd7, 8'hE3, 8'h00, 8'h00},
    {4'd7, 8'hE1, 8'hF0, 8'hF0}, {4'd7, 8'hF2, 8'h7E, 8'h7E}
  };

  function automatic string tag_name(logic [3:0] t);
    case (t)
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      default: return "R7";
    endcase
  endfunction

  // Expected power-on contents, restated from R3.
  function automatic logic [7:0] boot_byte(int i);
    if (i == 'hE0) return 8'h3C;
    if (i == 'hE2) return 8'h03;
    if (i == 'hE3) return 8'hFC;
    if (i == 'hE6) return 8'hDE;
    if (i == 'hE7) return 8'hFE;
    if (i == 'hE8) return 8'hBE;
    return 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [7:0] rb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R3 rdata reset", io_rdata, 8'hFF);
    win_en = 1'b1;

    // R3: index resets to 0, then sweep every entry.
    io_read(P_DAT, rb);
    check("R3 index 0", rb, 8'h00);
    for (int i = 0; i < 256; i++) begin
      io_write(P_IDX, 8'(i));
      io_read(P_DAT, rb);
      check("R3", rb, boot_byte(i));
    end

    // Table walk: R1 index load, R2 read-back.
    for (int v = 0; v < NV; v++) begin
      io_write(P_IDX, VEC[v][23:16]);
      io_write(P_DAT, VEC[v][15:8]);
      io_read(P_DAT, rb);
      check(tag_name(VEC[v][27:24]), rb, VEC[v][7:0]);
    end

    // R2: output holds without a read strobe.
    io_write(P_IDX, 8'hE0);
    io_write(P_DAT, 8'h99);
    repeat (2) @(negedge clk);
    check("R2 hold", io_rdata, 8'h7E);
    io_read(P_DAT, rb);
    check("R2", rb, 8'h99);

    // R10: read at index port returns the entry.
    io_write(P_IDX, 8'hE1);
    io_read(P_IDX, rb);
    check("R10", rb, 8'hF0);

    // R9: neighbouring addresses do nothing.
    io_write(16'h03EF, 8'hE0);
    io_write(16'h03F2, 8'h00);
    io_read(P_DAT, rb);
    check("R9 write", rb, 8'hF0);
    io_read(16'h03F2, rb);
    check("R9 read", rb, 8'hF0);

    // R8: disabled window.
    win_en = 1'b0;
    io_write(P_IDX, 8'hE0);
    io_write(P_DAT, 8'h00);
    io_read(P_DAT, rb);
    check("R8 read", rb, 8'hFF);
    win_en = 1'b1;
    io_read(P_DAT, rb);
    check("R8 no change", rb, 8'hF0);

    // R5 acceptance after reset: reset then rewrite keyed byte.
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    io_write(P_IDX, 8'hE0);
    io_read(P_DAT, rb);
    check("R3 after rerun reset", rb, 8'h3C);
    io_write(P_IDX, 8'hE7);
    io_write(P_DAT, 8'hFE);
    io_read(P_DAT, rb);
    check("R5 key", rb, 8'hFE);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule